// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Miss Classification

This block is a read-only cache with one line per set, placed between a requester and a slower memory that returns one byte per handshake. The requester presents a byte address. One cycle after a hit, or one cycle after a line fill finishes, the cache returns the byte together with a flag that says how the lookup went: hit, cold miss or conflict miss.

The address is cut into a byte offset, a set index and a tag. A lookup hits only when the indexed line holds valid contents and its tag matches. On any miss the cache fetches the whole block from the backing memory, one byte per beat, starting at offset zero. It then overwrites the indexed line and returns the requested byte. While the fill runs, the requester is held off. Three saturating counters record hits, cold misses and conflict misses. A flush input invalidates every line in a single cycle.

Top module: `dm_cache`

## Requirements
- R1: The low log2(BLOCK_BYTES) address bits are the byte offset, the next log2(SETS) bits select the set, and the remaining high bits are the tag.
- R2: An accepted request whose indexed line is valid with a matching tag is a hit. The cycle after acceptance, `resp_valid_o` and `resp_hit_o` are high and no backing-memory beat takes place.
- R3: A miss fetches the whole block as BLOCK_BYTES beats at consecutive addresses starting at the block base. `mem_addr_o` and `mem_req_o` hold until `mem_valid_i` completes each beat.
- R4: `req_ready_o` stays low from the cycle after a miss is accepted until the fill ends. The response appears in the cycle after the final beat.
- R5: A miss to a line whose valid bit is clear is reported with `resp_cold_o` high.
- R6: A miss to a valid line that holds a different tag is reported with `resp_conflict_o` high and replaces that line. Blocks that share a set and alternate therefore miss on every access.
- R7: After a fill, a read of any other byte of the same block hits.
- R8: When `resp_valid_o` is high, exactly one of `resp_hit_o`, `resp_cold_o` and `resp_conflict_o` is high. When it is low, all three are low.
- R9: A one-cycle `flush_i` invalidates every line and holds `req_ready_o` low in that cycle. It leaves the counters unchanged.
- R10: Reset invalidates every line, clears all three counters and `resp_valid_o`, drops `mem_req_o` and leaves `req_ready_o` high.
- R11: Each accepted request raises the counter of its class by exactly one. A counter that reaches its all-ones value stays there.
- R12: The returned byte equals the backing-memory byte at the requested address, on hits and on misses alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all lines this cycle |
| req_valid_i | input | 1 | Read request present |
| req_addr_i | input | ADDR_W | Byte address of the request |
| req_ready_o | output | 1 | Request accepted when high together with `req_valid_i` |
| resp_valid_o | output | 1 | Response byte and class valid |
| resp_data_o | output | 8 | Returned byte |
| resp_hit_o | output | 1 | Response came from a hit |
| resp_cold_o | output | 1 | Response came from a cold miss |
| resp_conflict_o | output | 1 | Response came from a conflict miss |
| mem_req_o | output | 1 | Backing-memory beat requested |
| mem_addr_o | output | ADDR_W | Byte address of the current beat |
| mem_valid_i | input | 1 | Beat complete, `mem_data_i` valid |
| mem_data_i | input | 8 | Byte from backing memory |
| hit_cnt_o | output | CNT_W | Saturating hit count |
| cold_cnt_o | output | CNT_W | Saturating cold-miss count |
| conflict_cnt_o | output | CNT_W | Saturating conflict-miss count |

## Verification
The checks assume that the backing memory raises `mem_valid_i` only while `mem_req_o` is high. They also assume that `flush_i` arrives only while no fill is running, because a flush during a fill would leave the refilled line invalid. The bench memory model answers every other cycle, so each fill has both stalled cycles and completed beats. Flush is pulsed only when `req_ready_o` is high and no request is pending. Addresses always fit inside ADDR_W. SETS and BLOCK_BYTES are powers of two with at least one tag bit left over.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic {ST_IDLE, ST_FILL} dmc_state_e;
  typedef enum logic [1:0] {KIND_HIT, KIND_COLD, KIND_CONFLICT} dmc_kind_e;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
  parameter int ADDR_W = 16,
  parameter int OFF_B  = 4,
  parameter int IDX_B  = 6,
  localparam int TAG_W  = ADDR_W - OFF_B - IDX_B,
  localparam int OFF_WS = (OFF_B > 0) ? OFF_B : 1,
  localparam int IDX_WS = (IDX_B > 0) ? IDX_B : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic [IDX_WS-1:0] idx_o,
  output logic [OFF_WS-1:0] off_o
);
  assign tag_o = addr_i[ADDR_W-1 -: TAG_W];

  if (OFF_B == 0) begin : g_no_off
    assign off_o = '0;
  end else begin : g_off
    assign off_o = addr_i[OFF_B-1:0];
  end

  if (IDX_B == 0) begin : g_no_idx
    assign idx_o = '0;
  end else begin : g_idx
    assign idx_o = addr_i[OFF_B +: IDX_B];
  end
endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
  parameter int SETS        = 64,
  parameter int BLOCK_BYTES = 16,
  parameter int TAG_W       = 6,
  parameter int IDX_WS      = 6,
  parameter int OFF_WS      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [IDX_WS-1:0] rd_idx_i,
  input  logic [OFF_WS-1:0] rd_off_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [7:0]        rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_WS-1:0] wr_idx_i,
  input  logic [OFF_WS-1:0] wr_off_i,
  input  logic [7:0]        wr_data_i,
  input  logic              commit_i,
  input  logic [IDX_WS-1:0] commit_idx_i,
  input  logic [TAG_W-1:0]  commit_tag_i
);
  localparam int LINE_W = BLOCK_BYTES * 8;

  logic [SETS-1:0]             valid_w;
  logic [SETS*TAG_W-1:0]       tag_flat;
  logic [SETS*LINE_W-1:0]      data_flat;

  for (genvar g = 0; g < SETS; g++) begin : g_set
    logic             v_q;
    logic [TAG_W-1:0] t_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                            v_q <= 1'b0;
      else if (flush_i)                                       v_q <= 1'b0;
      else if (commit_i && commit_idx_i == IDX_WS'(g))        v_q <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (commit_i && commit_idx_i == IDX_WS'(g)) t_q <= commit_tag_i;
    end

    assign valid_w[g]                  = v_q;
    assign tag_flat[g*TAG_W +: TAG_W]  = t_q;

    for (genvar b = 0; b < BLOCK_BYTES; b++) begin : g_byte
      logic [7:0] d_q;
      always_ff @(posedge clk_i) begin
        if (wr_en_i && wr_idx_i == IDX_WS'(g) && wr_off_i == OFF_WS'(b)) d_q <= wr_data_i;
      end
      assign data_flat[g*LINE_W + b*8 +: 8] = d_q;
    end
  end

  assign rd_valid_o = valid_w[rd_idx_i];
  assign rd_tag_o   = tag_flat[int'(rd_idx_i)*TAG_W +: TAG_W];
  assign rd_data_o  = data_flat[int'(rd_idx_i)*LINE_W + int'(rd_off_i)*8 +: 8];
endmodule

// File: rtl/dmc_sat_counter.sv
module dmc_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (inc_i && ~&cnt_q)     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dm_cache.sv
module dm_cache
  import dmc_pkg::*;
#(
  parameter int SETS        = 64,
  parameter int BLOCK_BYTES = 16,
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              resp_valid_o,
  output logic [7:0]        resp_data_o,
  output logic              resp_hit_o,
  output logic              resp_cold_o,
  output logic              resp_conflict_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [7:0]        mem_data_i,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  cold_cnt_o,
  output logic [CNT_W-1:0]  conflict_cnt_o
);
  localparam int OFF_B  = $clog2(BLOCK_BYTES);
  localparam int IDX_B  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_B - IDX_B;
  localparam int OFF_WS = (OFF_B > 0) ? OFF_B : 1;
  localparam int IDX_WS = (IDX_B > 0) ? IDX_B : 1;

  logic [TAG_W-1:0]  a_tag;
  logic [IDX_WS-1:0] a_idx;
  logic [OFF_WS-1:0] a_off;

  logic              line_valid;
  logic [TAG_W-1:0]  line_tag;
  logic [7:0]        line_byte;

  dmc_state_e        state_q;
  logic [TAG_W-1:0]  pend_tag_q;
  logic [IDX_WS-1:0] pend_idx_q;
  logic [OFF_WS-1:0] pend_off_q;
  dmc_kind_e         pend_kind_q;
  logic [OFF_WS-1:0] beat_q;
  logic [7:0]        want_byte_q;

  logic              resp_valid_q;
  logic [7:0]        resp_data_q;
  dmc_kind_e         resp_kind_q;

  logic accept, hit, beat_done, last_beat, fill_done;

  dmc_addr_split #(.ADDR_W(ADDR_W), .OFF_B(OFF_B), .IDX_B(IDX_B)) split_i (
    .addr_i (req_addr_i),
    .tag_o  (a_tag),
    .idx_o  (a_idx),
    .off_o  (a_off)
  );

  assign beat_done = (state_q == ST_FILL) && mem_valid_i;
  assign last_beat = (beat_q == OFF_WS'(BLOCK_BYTES - 1));
  assign fill_done = beat_done && last_beat;

  dmc_line_store #(
    .SETS(SETS), .BLOCK_BYTES(BLOCK_BYTES), .TAG_W(TAG_W), .IDX_WS(IDX_WS), .OFF_WS(OFF_WS)
  ) store_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .rd_idx_i     (a_idx),
    .rd_off_i     (a_off),
    .rd_valid_o   (line_valid),
    .rd_tag_o     (line_tag),
    .rd_data_o    (line_byte),
    .wr_en_i      (beat_done),
    .wr_idx_i     (pend_idx_q),
    .wr_off_i     (beat_q),
    .wr_data_i    (mem_data_i),
    .commit_i     (fill_done),
    .commit_idx_i (pend_idx_q),
    .commit_tag_i (pend_tag_q)
  );

  assign req_ready_o = (state_q == ST_IDLE) && !flush_i;
  assign accept      = req_valid_i && req_ready_o;
  assign hit         = line_valid && (line_tag == a_tag);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pend_tag_q  <= '0;
      pend_idx_q  <= '0;
      pend_off_q  <= '0;
      pend_kind_q <= KIND_COLD;
      beat_q      <= '0;
      want_byte_q <= '0;
    end else begin
      if (accept && !hit) begin
        state_q     <= ST_FILL;
        pend_tag_q  <= a_tag;
        pend_idx_q  <= a_idx;
        pend_off_q  <= a_off;
        pend_kind_q <= line_valid ? KIND_CONFLICT : KIND_COLD;
        beat_q      <= '0;
      end else if (beat_done) begin
        beat_q <= beat_q + 1'b1;
        if (beat_q == pend_off_q) want_byte_q <= mem_data_i;
        if (last_beat) state_q <= ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_q <= 1'b0;
      resp_data_q  <= '0;
      resp_kind_q  <= KIND_HIT;
    end else begin
      resp_valid_q <= 1'b0;
      if (accept && hit) begin
        resp_valid_q <= 1'b1;
        resp_data_q  <= line_byte;
        resp_kind_q  <= KIND_HIT;
      end else if (fill_done) begin
        resp_valid_q <= 1'b1;
        resp_data_q  <= (beat_q == pend_off_q) ? mem_data_i : want_byte_q;
        resp_kind_q  <= pend_kind_q;
      end
    end
  end

  assign resp_valid_o    = resp_valid_q;
  assign resp_data_o     = resp_data_q;
  assign resp_hit_o      = resp_valid_q && (resp_kind_q == KIND_HIT);
  assign resp_cold_o     = resp_valid_q && (resp_kind_q == KIND_COLD);
  assign resp_conflict_o = resp_valid_q && (resp_kind_q == KIND_CONFLICT);

  assign mem_req_o  = (state_q == ST_FILL);
  assign mem_addr_o = (ADDR_W'(pend_tag_q) << (IDX_B + OFF_B))
                    | (ADDR_W'(pend_idx_q) << OFF_B)
                    | ADDR_W'(beat_q);

  logic [2:0] inc;
  logic [2:0][CNT_W-1:0] cnt;
  assign inc[0] = accept && hit;
  assign inc[1] = accept && !line_valid;
  assign inc[2] = accept && line_valid && !hit;

  for (genvar k = 0; k < 3; k++) begin : g_cnt
    dmc_sat_counter #(.W(CNT_W)) cnt_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc[k]),
      .cnt_o  (cnt[k])
    );
  end

  assign hit_cnt_o      = cnt[0];
  assign cold_cnt_o     = cnt[1];
  assign conflict_cnt_o = cnt[2];
endmodule

// File: rtl/dm_cache_chk.sv
module dm_cache_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flush_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              resp_valid_o,
  input logic              resp_hit_o,
  input logic              resp_cold_o,
  input logic              resp_conflict_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_valid_i,
  input logic [CNT_W-1:0]  hit_cnt_o,
  input logic [CNT_W-1:0]  conflict_cnt_o
);
  // R4
  stall_during_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);

  // R3
  beat_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R8
  resp_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $onehot({resp_hit_o, resp_cold_o, resp_conflict_o}));

  // R8
  idle_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_valid_o |-> !(resp_hit_o || resp_cold_o || resp_conflict_o));

  // R9
  flush_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !req_ready_o);

  // R2
  hit_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (resp_hit_o || mem_req_o));

  // R11
  hit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_cnt_o != $past(hit_cnt_o)) |-> (hit_cnt_o == $past(hit_cnt_o) + 1'b1));

  // R11
  hit_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_cnt_o != $past(hit_cnt_o)) |-> $past(req_valid_i && req_ready_o));

  // R11
  conflict_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&conflict_cnt_o) |=> (&conflict_cnt_o));
endmodule

bind dm_cache dm_cache_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .flush_i         (flush_i),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .resp_valid_o    (resp_valid_o),
  .resp_hit_o      (resp_hit_o),
  .resp_cold_o     (resp_cold_o),
  .resp_conflict_o (resp_conflict_o),
  .mem_req_o       (mem_req_o),
  .mem_addr_o      (mem_addr_o),
  .mem_valid_i     (mem_valid_i),
  .hit_cnt_o       (hit_cnt_o),
  .conflict_cnt_o  (conflict_cnt_o)
);

// File: tb/dm_cache_tb_top.sv
module dm_cache_tb_top;
  localparam int AW = 5;
  localparam int CW = 3;
  localparam int KH = 0, KC = 1, KX = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic flush_i = 1'b0;
  logic req_valid_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic req_ready_o, resp_valid_o, resp_hit_o, resp_cold_o, resp_conflict_o, mem_req_o;
  logic [7:0] resp_data_o;
  logic [AW-1:0] mem_addr_o;
  logic mem_valid_i = 1'b0;
  logic [7:0] mem_data_i = '0;
  logic [CW-1:0] hit_cnt_o, cold_cnt_o, conflict_cnt_o;

  always #5 clk_i = ~clk_i;

  dm_cache #(.SETS(4), .BLOCK_BYTES(2), .ADDR_W(AW), .CNT_W(CW)) dut_i (.*);

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return 8'((int'(a) * 29 + 90) & 255);
  endfunction

  // backing memory: one beat every other cycle
  always @(posedge clk_i) begin
    mem_valid_i <= mem_req_o && !mem_valid_i;
    mem_data_i  <= mem_byte(mem_addr_o);
  end

  int beats = 0;
  logic [AW-1:0] first_addr = '0;
  logic [AW-1:0] prev_addr = '0;
  logic seq_bad = 1'b0;
  always @(posedge clk_i) begin
    if (mem_req_o && mem_valid_i) begin
      if (beats == 0) first_addr <= mem_addr_o;
      else if (mem_addr_o != prev_addr + 1'b1) seq_bad <= 1'b1;
      prev_addr <= mem_addr_o;
      beats <= beats + 1;
    end
  end

  int total = 0, fails = 0;
  bit done = 0;
  int e_hit = 0, e_cold = 0, e_conf = 0;
  localparam int CMAX = (1 << CW) - 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_cnts(input string req);
    chk(int'(hit_cnt_o) == e_hit, req, int'(hit_cnt_o), e_hit);
    chk(int'(cold_cnt_o) == e_cold, req, int'(cold_cnt_o), e_cold);
    chk(int'(conflict_cnt_o) == e_conf, req, int'(conflict_cnt_o), e_conf);
  endtask

  task automatic read_chk(input logic [AW-1:0] a, input int kind, input string req);
    int n;
    bit stall_bad;
    @(negedge clk_i);
    n = 0;
    while (!req_ready_o && n < 100) begin @(negedge clk_i); n++; end
    beats = 0; seq_bad = 1'b0;
    req_valid_i = 1'b1; req_addr_i = a;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    n = 0; stall_bad = 0;
    while (!resp_valid_o && n < 100) begin
      if (req_ready_o) stall_bad = 1;
      @(negedge clk_i); n++;
    end
    if (kind == KH) e_hit = (e_hit < CMAX) ? e_hit + 1 : e_hit;
    if (kind == KC) e_cold = (e_cold < CMAX) ? e_cold + 1 : e_cold;
    if (kind == KX) e_conf = (e_conf < CMAX) ? e_conf + 1 : e_conf;
    chk(resp_valid_o, {req, " resp_valid"}, int'(resp_valid_o), 1);
    chk(resp_data_o == mem_byte(a), "R12 data", int'(resp_data_o), int'(mem_byte(a)));
    chk({resp_hit_o, resp_cold_o, resp_conflict_o} == 3'(1 << (2 - kind)),
        {req, " R8 class"}, int'({resp_hit_o, resp_cold_o, resp_conflict_o}),
        1 << (2 - kind));
    chk(!stall_bad, "R4 ready low during fill", int'(stall_bad), 0);
    if (kind == KH) begin
      chk(beats == 0, "R2 no beat on hit", beats, 0);
    end else begin
      chk(beats == 2 && !seq_bad, "R3 beat count", beats, 2);
      chk(first_addr == {a[AW-1:1], 1'b0}, "R1 R3 block base", int'(first_addr),
          int'({a[AW-1:1], 1'b0}));
    end
    chk_cnts({req, " R11 counters"});
  endtask

  // {addr[4:0], kind[1:0]}; tag=[4:3], set=[2:1], offset=[0]
  localparam logic [6:0] VEC [12] = '{
    {5'b00000, 2'd1}, {5'b00001, 2'd0}, {5'b00110, 2'd1}, {5'b01000, 2'd2},
    {5'b00110, 2'd0}, {5'b00000, 2'd2}, {5'b01001, 2'd2}, {5'b00001, 2'd2},
    {5'b00000, 2'd0}, {5'b10011, 2'd1}, {5'b10010, 2'd0}, {5'b11111, 2'd2}
  };

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk(req_ready_o && !mem_req_o && !resp_valid_o, "R10 reset outputs",
        int'({req_ready_o, mem_req_o, resp_valid_o}), 4);
    chk_cnts("R10 reset counters");
    rst_ni = 1'b1;

    // R5 R6 R7 table walk
    for (int i = 0; i < 12; i++)
      read_chk(VEC[i][6:2], int'(VEC[i][1:0]), $sformatf("R5 R6 R7 vec%0d", i));

    // R9 flush: ready low, counters kept, lines invalid
    @(negedge clk_i);
    flush_i = 1'b1; #1;
    chk(!req_ready_o, "R9 ready during flush", int'(req_ready_o), 0);
    @(negedge clk_i);
    flush_i = 1'b0;
    chk_cnts("R9 counters after flush");
    read_chk(5'b00110, KC, "R9 cold after flush");
    read_chk(5'b10011, KC, "R9 set1 cold after flush");

    // R11 saturation
    for (int i = 0; i < 4; i++) read_chk(5'b00111, KH, "R11 hit saturate");
    read_chk(5'b11110, KX, "R11 conflict to 6");
    read_chk(5'b00110, KX, "R11 conflict to 7");
    read_chk(5'b11111, KX, "R11 conflict held at 7");

    // R10 reset mid-fill
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = 5'b01010;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    rst_ni = 1'b0; e_hit = 0; e_cold = 0; e_conf = 0;
    #1;
    chk(req_ready_o && !mem_req_o, "R10 reset mid-fill", int'({req_ready_o, mem_req_o}), 2);
    chk_cnts("R10 counters cleared");
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    read_chk(5'b00110, KC, "R10 cold after reset");

    finish_run();
  end
endmodule